// File: doc/BRIEF.md
# Register File with Two RAM Windows

This block connects a simple CPU-side register port to the parameter and status registers of two cipher engines, one for encryption and one for decryption. It also connects that port to the CPU-side ports of two external dual-port RAMs. The CPU writes with a single-cycle word strobe, a 16-bit byte address, 32-bit data and four byte enables. It reads by pulsing a request and then waiting for a valid pulse that carries the data.

The upper three address bits choose the target. Two codes open a window onto one of the RAMs, and every other code reaches the control registers. Each RAM window holds a 1 KiB payload part followed by a 1 KiB associated-data part.

The control registers hold the following:
- two 7-bit RAM start pointers;
- associated-data and payload lengths for each engine;
- a 256-bit key and a 96-bit IV for each engine;
- a 128-bit tag for each engine, captured from that engine when it signals that the tag is valid.

Writing a payload length also starts the matching engine. Reading the same address returns that engine's busy flag. Read timing is set by a two-state sequencer. The states are `RD_IDLE` (no request pending) and `RD_LATCH` (a request was captured on the previous edge). `RD_IDLE` moves to `RD_LATCH` when a request is seen, and `RD_LATCH` stays in `RD_LATCH` when a further request arrives. Either state goes to `RD_IDLE` when no request is present.

Top module: `ctl_ram_window_regs`

## Requirements
- R1: Address bits [15:13] choose the target. Code 3'b001 drives a write to RAM window 1, code 3'b010 drives a write to RAM window 2, and any other code (including 3'b011) goes to the control registers. Inside a window the RAM word address is address bits [10:2]. For example, byte address 0x2004 writes RAM1 word 1.
- R2: The four byte enables appear unchanged on the written RAM's byte-enable port, with bit n covering data bits [8n+7:8n]. The payload part of a window starts at window offset 0x000 (word 0). The associated-data part starts at offset 0x400 (word 256).
- R3: A read request returns its data with a one-cycle valid pulse two clock cycles after the request is sampled. Requests on consecutive cycles return on consecutive cycles, in order.
- R4: Control word addresses are as follows. 0x00 and 0x04 hold the 7-bit RAM1 and RAM2 start pointers. 0x08 and 0x0C hold the encrypt and decrypt associated-data lengths (16 bits). 0x10 and 0x14 hold the encrypt and decrypt payload lengths (16 bits). 0x20–0x3C hold the encrypt key and 0x40–0x5C the decrypt key. 0x60–0x68 hold the encrypt IV and 0x70–0x78 the decrypt IV. 0x80–0x8C hold the encrypt tag and 0x90–0x9C the decrypt tag. The lowest address of every multi-word value holds its least significant 32 bits. Pointers, keys and IVs read back what was stored.
- R5: A write to 0x10 (or 0x14) stores the length in bits [15:0]. It also raises the encrypt (or decrypt) start output for exactly the one cycle after the write edge. The other start output stays low.
- R6: A read of 0x10 (or 0x14) returns the encrypt (or decrypt) busy input in bit 0 and zero in bits [31:1].
- R7: While an engine's tag-valid input is high on a clock edge, its 128-bit tag is captured. While it is low, the stored tag is kept.
- R8: Length registers at 0x08 and 0x0C read as zero, as do unmapped control addresses (for example 0x6C, 0x1C, 0xA0). Writes to unmapped control addresses change no register.
- R9: Byte enables apply to the control registers as well. Only the bytes whose enable is set are updated.
- R10: After reset, all control registers, both start outputs and the read-valid output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 16 | Byte address for the current write or read request |
| reg_wr_data | input | 32 | Write data |
| reg_wr_be | input | 4 | Write byte enables |
| reg_rd_req | input | 1 | Read request, one cycle per read |
| reg_rd_valid | output | 1 | Read data valid pulse |
| reg_rd_data | output | 32 | Read data |
| win1_we | output | 1 | RAM1 CPU-port write enable |
| win1_be | output | 4 | RAM1 CPU-port byte enables |
| win1_addr | output | 9 | RAM1 CPU-port word address |
| win1_wdata | output | 32 | RAM1 CPU-port write data |
| win1_rdata | input | 32 | RAM1 CPU-port read data, one cycle after the address |
| win2_we | output | 1 | RAM2 CPU-port write enable |
| win2_be | output | 4 | RAM2 CPU-port byte enables |
| win2_addr | output | 9 | RAM2 CPU-port word address |
| win2_wdata | output | 32 | RAM2 CPU-port write data |
| win2_rdata | input | 32 | RAM2 CPU-port read data, one cycle after the address |
| enc_busy | input | 1 | Encrypt engine busy |
| dec_busy | input | 1 | Decrypt engine busy |
| enc_tag_valid | input | 1 | Encrypt tag capture strobe |
| enc_tag | input | 128 | Encrypt engine tag |
| dec_tag_valid | input | 1 | Decrypt tag capture strobe |
| dec_tag | input | 128 | Decrypt engine tag |
| ram1_ptr | output | 7 | RAM1 engine-side start pointer |
| ram2_ptr | output | 7 | RAM2 engine-side start pointer |
| enc_aad_len | output | 16 | Encrypt associated-data length |
| dec_aad_len | output | 16 | Decrypt associated-data length |
| enc_data_len | output | 16 | Encrypt payload length |
| dec_data_len | output | 16 | Decrypt payload length |
| enc_key | output | 256 | Encrypt key |
| dec_key | output | 256 | Decrypt key |
| enc_iv | output | 96 | Encrypt IV |
| dec_iv | output | 96 | Decrypt IV |
| enc_start | output | 1 | Encrypt start pulse |
| dec_start | output | 1 | Decrypt start pulse |

## Verification
The assertions assume the following about the inputs:
- Write and read strobes are clean single-cycle pulses, sampled at clock edges, with the address held for the cycle.
- Tag-valid and busy are driven by the engines independently of the register port.
- The external RAMs return read data one cycle after they see an address.

The stimulus applies every input a little after a rising edge and releases strobes after one edge. A RAM model in the bench follows the one-cycle read contract. Busy is held steady across each read that samples it. Back-to-back reads are issued only as single-cycle requests on adjacent cycles.

// File: rtl/cwr_pkg.sv
package cwr_pkg;

    localparam int CPU_DW = 32;
    localparam int CPU_BW = CPU_DW / 8;

    // Word indices (byte address / 4) inside the control area
    localparam int IDX_PTR1  = 0;
    localparam int IDX_PTR2  = 1;
    localparam int IDX_EAAD  = 2;
    localparam int IDX_DAAD  = 3;
    localparam int IDX_ELEN  = 4;
    localparam int IDX_DLEN  = 5;
    localparam int IDX_EKEY  = 8;
    localparam int IDX_DKEY  = 16;
    localparam int IDX_EIV   = 24;
    localparam int IDX_DIV   = 28;
    localparam int IDX_ETAG  = 32;
    localparam int IDX_DTAG  = 36;

    typedef enum logic [1:0] {
        AREA_REGS = 2'd0,
        AREA_WIN1 = 2'd1,
        AREA_WIN2 = 2'd2
    } area_e;

    typedef enum logic [0:0] {
        RD_IDLE  = 1'b0,
        RD_LATCH = 1'b1
    } rd_state_e;

    function automatic area_e area_of(input logic [2:0] sel);
        area_e a;
        case (sel)
            3'b001:  a = AREA_WIN1;
            3'b010:  a = AREA_WIN2;
            default: a = AREA_REGS;
        endcase
        return a;
    endfunction

    function automatic logic [CPU_DW-1:0] byte_merge(
        input logic [CPU_DW-1:0] old_w,
        input logic [CPU_DW-1:0] new_w,
        input logic [CPU_BW-1:0] be
    );
        logic [CPU_DW-1:0] r;
        r = old_w;
        for (int b = 0; b < CPU_BW; b++) begin
            if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/cwr_decode.sv
module cwr_decode
    import cwr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 9
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              win1_we,
    output logic              win2_we,
    output logic              reg_we,
    output logic [IDX_W-1:0]  word_idx
);

    localparam int SEL_MSB = ADDR_W - 1;

    area_e area;
    logic  unused_dec_bits;

    assign area            = area_of(addr[SEL_MSB -: 3]);
    assign word_idx        = addr[IDX_W+1:2];
    assign unused_dec_bits = ^{addr[1:0], addr[SEL_MSB-3:IDX_W+2]};

    always_comb begin
        win1_we = 1'b0;
        win2_we = 1'b0;
        reg_we  = 1'b0;
        unique case (area)
            AREA_WIN1: win1_we = wr_en;
            AREA_WIN2: win2_we = wr_en;
            default:   reg_we  = wr_en;
        endcase
    end

endmodule

// File: rtl/cwr_ctrl_regs.sv
module cwr_ctrl_regs
    import cwr_pkg::*;
#(
    parameter int IDX_W     = 9,
    parameter int LEN_W     = 16,
    parameter int PTR_W     = 7,
    parameter int KEY_WORDS = 8,
    parameter int IV_WORDS  = 3,
    parameter int TAG_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_stb,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [CPU_DW-1:0]           wdata,
    input  logic [CPU_BW-1:0]           be,
    input  logic [IDX_W-1:0]            rd_idx,
    input  logic                        enc_busy,
    input  logic                        dec_busy,
    input  logic                        enc_tag_vld,
    input  logic [TAG_WORDS*CPU_DW-1:0] enc_tag,
    input  logic                        dec_tag_vld,
    input  logic [TAG_WORDS*CPU_DW-1:0] dec_tag,
    output logic [PTR_W-1:0]            ptr1,
    output logic [PTR_W-1:0]            ptr2,
    output logic [LEN_W-1:0]            enc_aad_len,
    output logic [LEN_W-1:0]            dec_aad_len,
    output logic [LEN_W-1:0]            enc_len,
    output logic [LEN_W-1:0]            dec_len,
    output logic [KEY_WORDS*CPU_DW-1:0] enc_key,
    output logic [KEY_WORDS*CPU_DW-1:0] dec_key,
    output logic [IV_WORDS*CPU_DW-1:0]  enc_iv,
    output logic [IV_WORDS*CPU_DW-1:0]  dec_iv,
    output logic                        enc_start,
    output logic                        dec_start,
    output logic [CPU_DW-1:0]           rd_word
);

    localparam int DW = CPU_DW;

    logic [DW-1:0] ekey_q [KEY_WORDS];
    logic [DW-1:0] dkey_q [KEY_WORDS];
    logic [DW-1:0] eiv_q  [IV_WORDS];
    logic [DW-1:0] div_q  [IV_WORDS];
    logic [DW-1:0] etag_q [TAG_WORDS];
    logic [DW-1:0] dtag_q [TAG_WORDS];

    // Byte-merged next values for the narrow registers
    logic [DW-1:0] ptr1_m, ptr2_m, eaad_m, daad_m, elen_m, dlen_m;
    logic          unused_merge_bits;

    assign ptr1_m = byte_merge(DW'(ptr1), wdata, be);
    assign ptr2_m = byte_merge(DW'(ptr2), wdata, be);
    assign eaad_m = byte_merge(DW'(enc_aad_len), wdata, be);
    assign daad_m = byte_merge(DW'(dec_aad_len), wdata, be);
    assign elen_m = byte_merge(DW'(enc_len), wdata, be);
    assign dlen_m = byte_merge(DW'(dec_len), wdata, be);

    assign unused_merge_bits = ^{ptr1_m[DW-1:PTR_W], ptr2_m[DW-1:PTR_W],
                                 eaad_m[DW-1:LEN_W], daad_m[DW-1:LEN_W],
                                 elen_m[DW-1:LEN_W], dlen_m[DW-1:LEN_W]};

    function automatic logic hit(input logic [IDX_W-1:0] idx, input int n);
        return idx == IDX_W'(n);
    endfunction

    // Pointers, lengths and start pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr1        <= '0;
            ptr2        <= '0;
            enc_aad_len <= '0;
            dec_aad_len <= '0;
            enc_len     <= '0;
            dec_len     <= '0;
            enc_start   <= 1'b0;
            dec_start   <= 1'b0;
        end else begin
            enc_start <= wr_stb && hit(wr_idx, IDX_ELEN);
            dec_start <= wr_stb && hit(wr_idx, IDX_DLEN);
            if (wr_stb) begin
                if (hit(wr_idx, IDX_PTR1)) ptr1        <= ptr1_m[PTR_W-1:0];
                if (hit(wr_idx, IDX_PTR2)) ptr2        <= ptr2_m[PTR_W-1:0];
                if (hit(wr_idx, IDX_EAAD)) enc_aad_len <= eaad_m[LEN_W-1:0];
                if (hit(wr_idx, IDX_DAAD)) dec_aad_len <= daad_m[LEN_W-1:0];
                if (hit(wr_idx, IDX_ELEN)) enc_len     <= elen_m[LEN_W-1:0];
                if (hit(wr_idx, IDX_DLEN)) dec_len     <= dlen_m[LEN_W-1:0];
            end
        end
    end

    // Key words
    for (genvar w = 0; w < KEY_WORDS; w++) begin : g_key
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ekey_q[w] <= '0;
                dkey_q[w] <= '0;
            end else if (wr_stb) begin
                if (hit(wr_idx, IDX_EKEY + w)) ekey_q[w] <= byte_merge(ekey_q[w], wdata, be);
                if (hit(wr_idx, IDX_DKEY + w)) dkey_q[w] <= byte_merge(dkey_q[w], wdata, be);
            end
        end
        assign enc_key[w*DW +: DW] = ekey_q[w];
        assign dec_key[w*DW +: DW] = dkey_q[w];
    end

    // IV words
    for (genvar w = 0; w < IV_WORDS; w++) begin : g_iv
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                eiv_q[w] <= '0;
                div_q[w] <= '0;
            end else if (wr_stb) begin
                if (hit(wr_idx, IDX_EIV + w)) eiv_q[w] <= byte_merge(eiv_q[w], wdata, be);
                if (hit(wr_idx, IDX_DIV + w)) div_q[w] <= byte_merge(div_q[w], wdata, be);
            end
        end
        assign enc_iv[w*DW +: DW] = eiv_q[w];
        assign dec_iv[w*DW +: DW] = div_q[w];
    end

    // Tag capture from the engines
    for (genvar w = 0; w < TAG_WORDS; w++) begin : g_tag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                etag_q[w] <= '0;
                dtag_q[w] <= '0;
            end else begin
                if (enc_tag_vld) etag_q[w] <= enc_tag[w*DW +: DW];
                if (dec_tag_vld) dtag_q[w] <= dec_tag[w*DW +: DW];
            end
        end
    end

    // Per-area read multiplexer for the control area
    always_comb begin
        rd_word = '0;
        if (hit(rd_idx, IDX_PTR1)) rd_word = DW'(ptr1);
        if (hit(rd_idx, IDX_PTR2)) rd_word = DW'(ptr2);
        if (hit(rd_idx, IDX_ELEN)) rd_word = DW'(enc_busy);
        if (hit(rd_idx, IDX_DLEN)) rd_word = DW'(dec_busy);
        for (int w = 0; w < KEY_WORDS; w++) begin
            if (hit(rd_idx, IDX_EKEY + w)) rd_word = ekey_q[w];
            if (hit(rd_idx, IDX_DKEY + w)) rd_word = dkey_q[w];
        end
        for (int w = 0; w < IV_WORDS; w++) begin
            if (hit(rd_idx, IDX_EIV + w)) rd_word = eiv_q[w];
            if (hit(rd_idx, IDX_DIV + w)) rd_word = div_q[w];
        end
        for (int w = 0; w < TAG_WORDS; w++) begin
            if (hit(rd_idx, IDX_ETAG + w)) rd_word = etag_q[w];
            if (hit(rd_idx, IDX_DTAG + w)) rd_word = dtag_q[w];
        end
    end

endmodule

// File: rtl/cwr_rd_seq.sv
module cwr_rd_seq
    import cwr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CPU_DW-1:0] win1_rdata,
    input  logic [CPU_DW-1:0] win2_rdata,
    input  logic [CPU_DW-1:0] reg_word,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [CPU_DW-1:0] rd_data
);

    localparam int SEL_MSB = ADDR_W - 1;

    rd_state_e         state, state_nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [CPU_DW-1:0] sel_word;
    logic              unused_seq_bits;

    assign rd_idx          = addr_q[IDX_W+1:2];
    assign unused_seq_bits = ^{addr_q[1:0], addr_q[SEL_MSB-3:IDX_W+2]};

    // State register and captured request address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= RD_IDLE;
            addr_q <= '0;
        end else begin
            state <= state_nxt;
            if (rd_req) addr_q <= rd_addr;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RD_IDLE:  state_nxt = rd_req ? RD_LATCH : RD_IDLE;
            RD_LATCH: state_nxt = rd_req ? RD_LATCH : RD_IDLE;
            default:  state_nxt = RD_IDLE;
        endcase
    end

    // Area selector on the captured address
    always_comb begin
        unique case (area_of(addr_q[SEL_MSB -: 3]))
            AREA_WIN1: sel_word = win1_rdata;
            AREA_WIN2: sel_word = win2_rdata;
            default:   sel_word = reg_word;
        endcase
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state == RD_LATCH);
            if (state == RD_LATCH) rd_data <= sel_word;
        end
    end

endmodule

// File: rtl/ctl_ram_window_regs.sv
module ctl_ram_window_regs
    import cwr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int RAM_AW    = 9,
    parameter int LEN_W     = 16,
    parameter int PTR_W     = 7,
    parameter int KEY_WORDS = 8,
    parameter int IV_WORDS  = 3,
    parameter int TAG_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr_en,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [CPU_DW-1:0]           reg_wr_data,
    input  logic [CPU_BW-1:0]           reg_wr_be,
    input  logic                        reg_rd_req,
    output logic                        reg_rd_valid,
    output logic [CPU_DW-1:0]           reg_rd_data,
    output logic                        win1_we,
    output logic [CPU_BW-1:0]           win1_be,
    output logic [RAM_AW-1:0]           win1_addr,
    output logic [CPU_DW-1:0]           win1_wdata,
    input  logic [CPU_DW-1:0]           win1_rdata,
    output logic                        win2_we,
    output logic [CPU_BW-1:0]           win2_be,
    output logic [RAM_AW-1:0]           win2_addr,
    output logic [CPU_DW-1:0]           win2_wdata,
    input  logic [CPU_DW-1:0]           win2_rdata,
    input  logic                        enc_busy,
    input  logic                        dec_busy,
    input  logic                        enc_tag_valid,
    input  logic [TAG_WORDS*CPU_DW-1:0] enc_tag,
    input  logic                        dec_tag_valid,
    input  logic [TAG_WORDS*CPU_DW-1:0] dec_tag,
    output logic [PTR_W-1:0]            ram1_ptr,
    output logic [PTR_W-1:0]            ram2_ptr,
    output logic [LEN_W-1:0]            enc_aad_len,
    output logic [LEN_W-1:0]            dec_aad_len,
    output logic [LEN_W-1:0]            enc_data_len,
    output logic [LEN_W-1:0]            dec_data_len,
    output logic [KEY_WORDS*CPU_DW-1:0] enc_key,
    output logic [KEY_WORDS*CPU_DW-1:0] dec_key,
    output logic [IV_WORDS*CPU_DW-1:0]  enc_iv,
    output logic [IV_WORDS*CPU_DW-1:0]  dec_iv,
    output logic                        enc_start,
    output logic                        dec_start
);

    localparam int IDX_W = RAM_AW;

    logic             reg_we;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [CPU_DW-1:0] reg_word;

    cwr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .win1_we  (win1_we),
        .win2_we  (win2_we),
        .reg_we   (reg_we),
        .word_idx (wr_idx)
    );

    // CPU-side RAM port: address follows the bus for reads and writes
    assign win1_addr  = wr_idx;
    assign win2_addr  = wr_idx;
    assign win1_be    = reg_wr_be;
    assign win2_be    = reg_wr_be;
    assign win1_wdata = reg_wr_data;
    assign win2_wdata = reg_wr_data;

    cwr_ctrl_regs #(
        .IDX_W(IDX_W), .LEN_W(LEN_W), .PTR_W(PTR_W),
        .KEY_WORDS(KEY_WORDS), .IV_WORDS(IV_WORDS), .TAG_WORDS(TAG_WORDS)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (reg_we),
        .wr_idx      (wr_idx),
        .wdata       (reg_wr_data),
        .be          (reg_wr_be),
        .rd_idx      (rd_idx),
        .enc_busy    (enc_busy),
        .dec_busy    (dec_busy),
        .enc_tag_vld (enc_tag_valid),
        .enc_tag     (enc_tag),
        .dec_tag_vld (dec_tag_valid),
        .dec_tag     (dec_tag),
        .ptr1        (ram1_ptr),
        .ptr2        (ram2_ptr),
        .enc_aad_len (enc_aad_len),
        .dec_aad_len (dec_aad_len),
        .enc_len     (enc_data_len),
        .dec_len     (dec_data_len),
        .enc_key     (enc_key),
        .dec_key     (dec_key),
        .enc_iv      (enc_iv),
        .dec_iv      (dec_iv),
        .enc_start   (enc_start),
        .dec_start   (dec_start),
        .rd_word     (reg_word)
    );

    cwr_rd_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rd_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (reg_rd_req),
        .rd_addr    (reg_addr),
        .win1_rdata (win1_rdata),
        .win2_rdata (win2_rdata),
        .reg_word   (reg_word),
        .rd_idx     (rd_idx),
        .rd_valid   (reg_rd_valid),
        .rd_data    (reg_rd_data)
    );

endmodule

// File: rtl/cwr_checker.sv
module cwr_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_wr_en,
    input logic [15:0]  reg_addr,
    input logic         reg_rd_req,
    input logic         reg_rd_valid,
    input logic         win1_we,
    input logic         win2_we,
    input logic         enc_start,
    input logic         dec_start,
    input logic [255:0] enc_key,
    input logic [95:0]  enc_iv
);

    logic to_regs;
    assign to_regs = (reg_addr[15:13] != 3'b001) && (reg_addr[15:13] != 3'b010);

    assert_rd_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_req |-> ##2 reg_rd_valid);

    assert_rd_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_valid |-> $past(reg_rd_req, 2));

    assert_win1_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr[15:13] == 3'b001) |-> (win1_we && !win2_we));

    assert_win2_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr[15:13] == 3'b010) |-> (win2_we && !win1_we));

    assert_win_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_en || to_regs) |-> !(win1_we || win2_we));

    assert_enc_start_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        enc_start |-> $past(reg_wr_en && to_regs && reg_addr[10:2] == 9'd4));

    assert_dec_start_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_start |-> $past(reg_wr_en && to_regs && reg_addr[10:2] == 9'd5));

    assert_key_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_wr_en) |-> ($stable(enc_key) && $stable(enc_iv)));

endmodule

bind ctl_ram_window_regs cwr_checker u_chk (.*);

// File: tb/ctl_ram_window_regs_bench.sv
module ctl_ram_window_regs_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [15:0]  reg_addr = '0;
    logic [31:0]  reg_wr_data = '0;
    logic [3:0]   reg_wr_be = '0;
    logic         reg_rd_req = 1'b0;
    logic         reg_rd_valid;
    logic [31:0]  reg_rd_data;
    logic         win1_we, win2_we;
    logic [3:0]   win1_be, win2_be;
    logic [8:0]   win1_addr, win2_addr;
    logic [31:0]  win1_wdata, win2_wdata;
    logic [31:0]  win1_rdata, win2_rdata;
    logic         enc_busy = 1'b0, dec_busy = 1'b0;
    logic         enc_tag_valid = 1'b0, dec_tag_valid = 1'b0;
    logic [127:0] enc_tag = '0, dec_tag = '0;
    logic [6:0]   ram1_ptr, ram2_ptr;
    logic [15:0]  enc_aad_len, dec_aad_len, enc_data_len, dec_data_len;
    logic [255:0] enc_key, dec_key;
    logic [95:0]  enc_iv, dec_iv;
    logic         enc_start, dec_start;

    int checks = 0;
    int fails  = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    logic [31:0] mem1 [512];
    logic [31:0] mem2 [512];

    always #5 clk = ~clk;

    ctl_ram_window_regs u_ctl_ram_window_regs (.*);

    // RAM models: one-cycle read, byte-enabled write
    initial begin
        for (int i = 0; i < 512; i++) begin
            mem1[i] = '0;
            mem2[i] = '0;
        end
    end

    always @(posedge clk) begin
        win1_rdata <= mem1[win1_addr];
        win2_rdata <= mem2[win2_addr];
        for (int b = 0; b < 4; b++) begin
            if (win1_we && win1_be[b]) mem1[win1_addr][b*8 +: 8] <= win1_wdata[b*8 +: 8];
            if (win2_we && win2_be[b]) mem2[win2_addr][b*8 +: 8] <= win2_wdata[b*8 +: 8];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Monitor: pops expected read words as valid pulses appear
    always @(negedge clk) begin
        if (rst_n && reg_rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected valid", 256'(reg_rd_data), 0);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(reg_rd_data == e, t, 256'(reg_rd_data), 256'(e));
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d; reg_wr_be = be;
        @(posedge clk); #1;
        reg_wr_en = 1'b0; reg_wr_be = '0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        reg_rd_req = 1'b1; reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        reg_rd_req = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 0);
        finish_run();
    end

    initial begin
        logic [255:0] kexp;
        logic [31:0]  mexp;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(reg_rd_valid == 0 && enc_start == 0 && dec_start == 0, "R10 reset strobes", 256'(reg_rd_valid), 0);
        chk(enc_key == 0 && dec_iv == 0 && ram1_ptr == 0 && enc_data_len == 0, "R10 reset regs", enc_key, 0);
        rd(16'h0080, 32'h0, "R10 reset tag reads zero");
        drain();

        // R4: pointers keep 7 bits
        wr(16'h0000, 32'hFFFF_FFFF, 4'hF);
        chk(ram1_ptr == 7'h7F, "R4 ram1 ptr", 256'(ram1_ptr), 256'h7F);
        wr(16'h0004, 32'h0000_0040, 4'hF);
        chk(ram2_ptr == 7'h40, "R4 ram2 ptr", 256'(ram2_ptr), 256'h40);
        rd(16'h0000, 32'h7F, "R4 ptr1 readback");
        drain();

        // R8: AAD length stored but reads zero
        wr(16'h0008, 32'h0000_1234, 4'hF);
        chk(enc_aad_len == 16'h1234, "R4 enc aad len", 256'(enc_aad_len), 256'h1234);
        wr(16'h000C, 32'h0000_0055, 4'hF);
        chk(dec_aad_len == 16'h0055, "R4 dec aad len", 256'(dec_aad_len), 256'h55);
        rd(16'h0008, 32'h0, "R8 aad length reads zero");
        drain();

        // R4: keys little-word-first
        kexp = '0;
        for (int w = 0; w < 8; w++) begin
            wr(16'h0020 + 16'(w*4), 32'h1111_0000 + 32'(w), 4'hF);
            kexp[w*32 +: 32] = 32'h1111_0000 + 32'(w);
        end
        chk(enc_key == kexp, "R4 enc key words", enc_key, kexp);
        wr(16'h0040, 32'h2222_0000, 4'hF);
        chk(dec_key[31:0] == 32'h2222_0000 && dec_key[255:32] == 0, "R4 dec key word0", dec_key, 256'h2222_0000);
        rd(16'h002C, 32'h1111_0003, "R4 enc key word3");
        drain();

        // R4: IVs
        for (int w = 0; w < 3; w++) wr(16'h0060 + 16'(w*4), 32'hA0A0_0000 + 32'(w), 4'hF);
        wr(16'h0074, 32'hB0B0_0001, 4'hF);
        chk(enc_iv == {32'hA0A0_0002, 32'hA0A0_0001, 32'hA0A0_0000}, "R4 enc iv", 256'(enc_iv), 0);
        rd(16'h0068, 32'hA0A0_0002, "R4 enc iv word2");
        rd(16'h0074, 32'hB0B0_0001, "R4 dec iv word1");
        drain();

        // R8: unmapped writes ignored, reads zero
        wr(16'h006C, 32'hDEAD_BEEF, 4'hF);
        wr(16'h00A0, 32'hDEAD_BEEF, 4'hF);
        chk(enc_iv == {32'hA0A0_0002, 32'hA0A0_0001, 32'hA0A0_0000} && dec_iv == {32'h0, 32'hB0B0_0001, 32'h0},
            "R8 unmapped write ignored", 256'(enc_iv), 0);
        chk(enc_key == kexp && ram1_ptr == 7'h7F && ram2_ptr == 7'h40, "R8 regs untouched", enc_key, kexp);
        rd(16'h006C, 32'h0, "R8 hole reads zero");
        rd(16'h001C, 32'h0, "R8 0x1C reads zero");
        rd(16'h00A0, 32'h0, "R8 0xA0 reads zero");
        drain();

        // R9: byte enables on control registers
        wr(16'h0020, 32'hAAAA_AA55, 4'b0001);
        chk(enc_key[31:0] == 32'h1111_0055, "R9 low byte only", 256'(enc_key[31:0]), 256'h1111_0055);
        wr(16'h0020, 32'h77BB_CCDD, 4'b1100);
        rd(16'h0020, 32'h77BB_0055, "R9 upper half only");
        drain();

        // R5: length write starts engine for one cycle
        wr(16'h0010, 32'hFFFF_0021, 4'hF);
        chk(enc_start == 1 && dec_start == 0, "R5 enc start pulse", 256'({enc_start, dec_start}), 256'b10);
        chk(enc_data_len == 16'h0021, "R5 enc length", 256'(enc_data_len), 256'h21);
        @(posedge clk); #1;
        chk(enc_start == 0, "R5 enc start one cycle", 256'(enc_start), 0);
        wr(16'h0014, 32'h0000_0100, 4'hF);
        chk(dec_start == 1 && enc_start == 0, "R5 dec start pulse", 256'({enc_start, dec_start}), 256'b01);
        chk(dec_data_len == 16'h0100, "R5 dec length", 256'(dec_data_len), 256'h100);
        @(posedge clk); #1;
        chk(dec_start == 0, "R5 dec start one cycle", 256'(dec_start), 0);

        // R6: busy status readback
        enc_busy = 1'b1;
        rd(16'h0010, 32'h1, "R6 enc busy high");
        drain();
        enc_busy = 1'b0; dec_busy = 1'b1;
        rd(16'h0010, 32'h0, "R6 enc busy low");
        rd(16'h0014, 32'h1, "R6 dec busy high");
        drain();
        dec_busy = 1'b0;

        // R7: tag capture
        @(posedge clk); #1;
        enc_tag = {32'hD4D4_D4D4, 32'hC3C3_C3C3, 32'hB2B2_B2B2, 32'hA1A1_A1A1};
        enc_tag_valid = 1'b1;
        dec_tag = {4{32'h9999_9999}};
        @(posedge clk); #1;
        enc_tag_valid = 1'b0;
        enc_tag = '0;
        rd(16'h0080, 32'hA1A1_A1A1, "R7 enc tag word0");
        rd(16'h008C, 32'hD4D4_D4D4, "R7 enc tag word3");
        rd(16'h0094, 32'h0, "R7 dec tag not captured");
        drain();
        dec_tag_valid = 1'b1;
        @(posedge clk); #1;
        dec_tag_valid = 1'b0;
        rd(16'h0098, 32'h9999_9999, "R7 dec tag captured");
        rd(16'h0084, 32'hB2B2_B2B2, "R7 enc tag held");
        drain();

        // R1/R2: RAM windows
        wr(16'h2004, 32'hCAFE_F00D, 4'hF);
        @(negedge clk);
        chk(mem1[1] == 32'hCAFE_F00D && mem2[1] == 0, "R1 0x2004 -> RAM1 word1", 256'(mem1[1]), 256'hCAFEF00D);
        wr(16'h4404, 32'hAABB_CCDD, 4'b0010);
        @(negedge clk);
        chk(mem2[257] == 32'h0000_CC00, "R2 byte enable into RAM2 AAD part", 256'(mem2[257]), 256'hCC00);
        wr(16'h2400, 32'h1234_5678, 4'hF);
        @(negedge clk);
        chk(mem1[256] == 32'h1234_5678 && mem1[0] == 0, "R2 AAD part at word 256", 256'(mem1[256]), 256'h12345678);
        rd(16'h2004, 32'hCAFE_F00D, "R1 RAM1 readback");
        rd(16'h4404, 32'h0000_CC00, "R2 RAM2 readback");
        rd(16'h2000, 32'h0, "R2 payload word0 untouched");
        drain();

        // R1: other area code reaches registers
        wr(16'h6004, 32'h0000_0015, 4'hF);
        @(negedge clk);
        chk(ram2_ptr == 7'h15 && mem1[1] == 32'hCAFE_F00D && mem2[1] == 0, "R1 area 011 to regs", 256'(ram2_ptr), 256'h15);

        // R3: exact latency and back-to-back reads
        @(posedge clk); #1;
        reg_rd_req = 1'b1; reg_addr = 16'h2004;
        exp_q.push_back(32'hCAFE_F00D); tag_q.push_back("R3 back-to-back first");
        @(posedge clk); #1;
        reg_addr = 16'h0000;
        exp_q.push_back(32'h7F); tag_q.push_back("R3 back-to-back second");
        chk(reg_rd_valid == 0, "R3 no valid after one edge", 256'(reg_rd_valid), 0);
        @(posedge clk); #1;
        reg_rd_req = 1'b0;
        chk(reg_rd_valid == 1, "R3 valid after two edges", 256'(reg_rd_valid), 1);
        @(posedge clk); #1;
        chk(reg_rd_valid == 1, "R3 second valid next cycle", 256'(reg_rd_valid), 1);
        @(posedge clk); #1;
        chk(reg_rd_valid == 0, "R3 valid drops", 256'(reg_rd_valid), 0);
        drain();

        mexp = 32'(exp_q.size());
        chk(mexp == 0, "R3 all reads returned", 256'(mexp), 0);
        finish_run();
    end

endmodule